// File: doc/BRIEF.md
# DMA Channel Control and Status Register Bank

This block holds the per-channel control and status logic of a four-channel DMA controller. A CPU reaches it over a simple register bus: an address, a write strobe with write data, and a read strobe with combinational read data. Each channel has one byte-wide register. Channel n sits at byte offset 2n. Toward the transfer engine, each channel drives a level enable, a one-cycle start strobe and a one-cycle abort strobe. The engine reports back with a per-channel terminal-count event. Peripherals raise per-channel hardware trigger requests, and a single non-maskable interrupt input halts every channel.

Each channel is a four-state machine. CH_OFF means disabled and idle. CH_ARMED means enabled and waiting for a trigger. CH_BUSY means a transfer is running. CH_SUSP means a transfer was halted by NMI or by a disable write and can be resumed. The named transitions are:
- enable (OFF→ARMED, on a write with bit 0 set)
- disable (ARMED→OFF)
- launch (ARMED→BUSY, on an accepted software or hardware start)
- finish (BUSY→OFF when single-shot, BUSY→ARMED in multi-transfer mode)
- halt (BUSY→SUSP, on NMI or a write with bit 0 clear)
- resume (SUSP→BUSY, on a write with bit 0 set)
- kill (BUSY or SUSP→OFF, on a write with bit 2 set)

A completion flag records each finish. Reading the channel's register clears the flag.

Top module: `dma_csr_top`

## Requirements
- R1: After reset, every register reads 0x00, all enables are 0, and no start or abort strobe is raised.
- R2: Channel n is selected at byte address 2n. The read format is bit 7 = completion flag, bit 3 = multi-transfer mode, bit 0 = enable, and all other bits read 0. Writes to bit 7 have no effect. An odd address or an address at or above 2×channels reads 0x00, and a write there changes nothing.
- R3: A write with bit 0 = 1 to a channel in CH_OFF enables it (CH_ARMED). A write with bit 0 = 0 to an armed channel disables it.
- R4: A write with bits 1 and 0 both set to a channel in CH_ARMED with its completion flag at 0 raises that channel's start strobe for exactly one cycle, beginning the cycle after the write. Otherwise the write raises no strobe. The strobe is never raised unless the channel was enabled in the cycle before.
- R5: In CH_ARMED, a hardware trigger produces a one-cycle start strobe in the next cycle. This happens if the completion flag is 0, or if multi-transfer mode (bit 3) is 1. Triggers in any other state are ignored.
- R6: A terminal-count event in CH_BUSY sets the completion flag. With bit 3 = 0, the enable drops to 0. With bit 3 = 1, the enable stays at 1.
- R7: A read of a channel returns the flag as it stood before the read and clears it afterwards. If a terminal-count event lands in the same cycle, the flag ends up set.
- R8: A write with bit 2 set to a channel in CH_BUSY or CH_SUSP raises a one-cycle abort strobe and clears the enable. In CH_ARMED, the same write clears the enable with no strobe.
- R9: NMI clears the enable of every channel. A busy channel moves to CH_SUSP, and a later write with bit 0 = 1 resumes it with enable 1 and no new start strobe.
- R10: Within one cycle, a kill write overrides a terminal-count event. NMI overrides the multi-transfer hold, so a channel that finishes during NMI ends up disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe (clears the completion flag of the selected channel) |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| tc_evt | input | NUM_CH | Terminal-count event per channel from the transfer engine |
| hw_req | input | NUM_CH | Hardware trigger request per channel |
| nmi | input | 1 | Non-maskable interrupt, halts all channels |
| ch_enable | output | NUM_CH | Channel enable level |
| ch_start | output | NUM_CH | One-cycle start strobe per channel |
| ch_abort | output | NUM_CH | One-cycle forced-termination strobe per channel |

## Verification
The completion flag can be set by a terminal-count event and cleared by a bus read in the same cycle. The bench provokes this by holding tc_evt and bus_rd together across one edge. It judges the result in two parts: the read returns the old flag value of 0, and a second read shows the flag at 1. Kill and finish are also made to coincide, and so are NMI and a multi-transfer finish. In both cases the enable and abort outputs are compared against the stated priority, and the flag is read back afterwards.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;

    typedef enum logic [1:0] {
        CH_OFF   = 2'd0,
        CH_ARMED = 2'd1,
        CH_BUSY  = 2'd2,
        CH_SUSP  = 2'd3
    } ch_state_e;

    localparam int FLD_DONE  = 7;
    localparam int FLD_MULTI = 3;
    localparam int FLD_KILL  = 2;
    localparam int FLD_GO    = 1;
    localparam int FLD_EN    = 0;

    typedef struct packed {
        logic multi;
        logic kill;
        logic go;
        logic en;
    } wr_cmd_t;

    function automatic wr_cmd_t unpack_cmd(input logic [7:0] d);
        wr_cmd_t c;
        c.multi = d[FLD_MULTI];
        c.kill  = d[FLD_KILL];
        c.go    = d[FLD_GO];
        c.en    = d[FLD_EN];
        return c;
    endfunction

    function automatic logic [7:0] pack_status(input logic done, input logic multi,
                                               input logic en);
        logic [7:0] r;
        r            = 8'h00;
        r[FLD_DONE]  = done;
        r[FLD_MULTI] = multi;
        r[FLD_EN]    = en;
        return r;
    endfunction

endpackage

// File: rtl/dma_csr_decode.sv
module dma_csr_decode #(
    parameter int ADDR_W = 4,
    parameter int NUM_CH = 4,
    parameter int CH_W   = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output logic              hit,
    output logic [CH_W-1:0]   idx,
    output logic [NUM_CH-1:0] wr_sel,
    output logic [NUM_CH-1:0] rd_sel
);
    localparam int UPPER_W = ADDR_W - CH_W - 1;

    logic [UPPER_W-1:0] upper;

    always_comb begin
        idx   = addr[CH_W:1];
        upper = addr[ADDR_W-1:CH_W+1];
        hit   = !addr[0] && (upper == '0) && (int'(idx) < NUM_CH);
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
        assign wr_sel[i] = wr && hit && (idx == CH_W'(i));
        assign rd_sel[i] = rd && hit && (idx == CH_W'(i));
    end

endmodule

// File: rtl/dma_csr_chan.sv
module dma_csr_chan
    import dma_csr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_sel,
    input  logic       rd_sel,
    input  logic [7:0] wdata,
    input  logic       tc_evt,
    input  logic       hw_req,
    input  logic       nmi,
    output logic [7:0] status,
    output logic       en_o,
    output logic       start_o,
    output logic       abort_o
);
    ch_state_e state_q, state_d;
    logic      done_q, done_d;
    logic      multi_q;
    logic      start_q, start_d;
    logic      abort_q, abort_d;
    wr_cmd_t   cmd;
    logic      sw_go, hw_go, tc_hit, kill_wr;

    always_comb begin
        cmd     = unpack_cmd(wdata);
        kill_wr = wr_sel && cmd.kill;
        sw_go   = wr_sel && cmd.go && cmd.en && !done_q;
        hw_go   = hw_req && (multi_q || !done_q);
        tc_hit  = tc_evt && (state_q == CH_BUSY);
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        start_d = 1'b0;
        abort_d = 1'b0;
        unique case (state_q)
            CH_OFF: begin
                if (!nmi && wr_sel && cmd.en && !cmd.kill)
                    state_d = CH_ARMED;                      // enable
            end
            CH_ARMED: begin
                if (nmi || kill_wr || (wr_sel && !cmd.en))
                    state_d = CH_OFF;                        // disable
                else if (sw_go || hw_go) begin
                    state_d = CH_BUSY;                       // launch
                    start_d = 1'b1;
                end
            end
            CH_BUSY: begin
                if (kill_wr) begin
                    state_d = CH_OFF;                        // kill
                    abort_d = 1'b1;
                end else if (tc_evt)
                    state_d = (multi_q && !nmi) ? CH_ARMED : CH_OFF; // finish
                else if (nmi || (wr_sel && !cmd.en))
                    state_d = CH_SUSP;                       // halt
            end
            CH_SUSP: begin
                if (kill_wr) begin
                    state_d = CH_OFF;                        // kill
                    abort_d = 1'b1;
                end else if (!nmi && wr_sel && cmd.en)
                    state_d = CH_BUSY;                       // resume
            end
            default: state_d = CH_OFF;
        endcase
    end

    always_comb begin
        if (tc_hit)
            done_d = 1'b1;
        else if (rd_sel)
            done_d = 1'b0;
        else
            done_d = done_q;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_OFF;
            done_q  <= 1'b0;
            multi_q <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= done_d;
            if (wr_sel)
                multi_q <= cmd.multi;
        end
    end

    // Output registers and decode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            start_q <= start_d;
            abort_q <= abort_d;
        end
    end

    always_comb begin
        en_o    = (state_q == CH_ARMED) || (state_q == CH_BUSY);
        start_o = start_q;
        abort_o = abort_q;
        status  = pack_status(done_q, multi_q, en_o);
    end

    AST_START_AFTER_EN: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> $past(en_o)); // R4
    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o); // R4
    AST_TC_SETS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_evt && state_q == CH_BUSY) |=> status[FLD_DONE]); // R6
    AST_SINGLE_SHOT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_evt && state_q == CH_BUSY && !multi_q) |=> !en_o); // R6
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel && !(tc_evt && state_q == CH_BUSY)) |=> !status[FLD_DONE]); // R7
    AST_ABORT_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> !en_o); // R8
    AST_NMI_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
        nmi |=> !en_o); // R9

endmodule

// File: rtl/dma_csr_rdmux.sv
module dma_csr_rdmux #(
    parameter int NUM_CH = 4,
    parameter int CH_W   = 2
) (
    input  logic                hit,
    input  logic [CH_W-1:0]     idx,
    input  logic [NUM_CH*8-1:0] regs,
    output logic [7:0]          rdata
);
    always_comb begin
        rdata = 8'h00;
        if (hit)
            rdata = regs[int'(idx)*8 +: 8];
    end
endmodule

// File: rtl/dma_csr_top.sv
module dma_csr_top
    import dma_csr_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_rd,
    output logic [7:0]        bus_rdata,
    input  logic [NUM_CH-1:0] tc_evt,
    input  logic [NUM_CH-1:0] hw_req,
    input  logic              nmi,
    output logic [NUM_CH-1:0] ch_enable,
    output logic [NUM_CH-1:0] ch_start,
    output logic [NUM_CH-1:0] ch_abort
);
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic                hit;
    logic [CH_W-1:0]     idx;
    logic [NUM_CH-1:0]   wr_sel, rd_sel;
    logic [NUM_CH*8-1:0] regs;

    dma_csr_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .CH_W(CH_W)) u_dec (
        .addr   (bus_addr),
        .wr     (bus_wr),
        .rd     (bus_rd),
        .hit    (hit),
        .idx    (idx),
        .wr_sel (wr_sel),
        .rd_sel (rd_sel)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        dma_csr_chan u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_sel  (wr_sel[i]),
            .rd_sel  (rd_sel[i]),
            .wdata   (bus_wdata),
            .tc_evt  (tc_evt[i]),
            .hw_req  (hw_req[i]),
            .nmi     (nmi),
            .status  (regs[i*8 +: 8]),
            .en_o    (ch_enable[i]),
            .start_o (ch_start[i]),
            .abort_o (ch_abort[i])
        );
    end

    dma_csr_rdmux #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_mux (
        .hit   (hit),
        .idx   (idx),
        .regs  (regs),
        .rdata (bus_rdata)
    );

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & 8'h76) == 8'h00); // R2
    AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> bus_rdata == 8'h00); // R2
    AST_NMI_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        nmi |=> ch_enable == '0); // R9

endmodule

// File: tb/sim_dma_csr_top.sv
module sim_dma_csr_top;
    localparam int CLK_NS = 10;
    localparam int NCH    = 4;
    localparam int AW     = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [AW-1:0]  bus_addr = '0;
    logic           bus_wr = 1'b0;
    logic [7:0]     bus_wdata = '0;
    logic           bus_rd = 1'b0;
    logic [7:0]     bus_rdata;
    logic [NCH-1:0] tc_evt = '0;
    logic [NCH-1:0] hw_req = '0;
    logic           nmi = 1'b0;
    logic [NCH-1:0] ch_enable, ch_start, ch_abort;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_NS/2) clk = ~clk;

    dma_csr_top #(.ADDR_W(AW), .NUM_CH(NCH)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .tc_evt(tc_evt), .hw_req(hw_req), .nmi(nmi),
        .ch_enable(ch_enable), .ch_start(ch_start), .ch_abort(ch_abort)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        tick();
        bus_rd = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_NS * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        summary();
    end

    initial begin
        logic [7:0] d;
        @(negedge clk);
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        chk("R1 enable", 32'(ch_enable), 0);
        chk("R1 start", 32'(ch_start), 0);
        chk("R1 abort", 32'(ch_abort), 0);
        for (int c = 0; c < NCH; c++) begin
            bus_read(AW'(2*c), d);
            chk("R1 reg", 32'(d), 0);
        end

        // R2 address map, read-only flag, reserved bits, misses
        bus_write(AW'(1), 8'h01);
        chk("R2 odd write ignored", 32'(ch_enable), 0);
        bus_write(AW'(2*NCH), 8'h01);
        chk("R2 out-of-range write ignored", 32'(ch_enable), 0);
        bus_write(AW'(0), 8'hF1);
        chk("R3 enable ch0", 32'(ch_enable), 1);
        bus_read(AW'(0), d);
        chk("R2 read format", 32'(d), 32'h01);
        bus_read(AW'(1), d);
        chk("R2 odd read zero", 32'(d), 0);
        bus_read(AW'(2*NCH), d);
        chk("R2 out-of-range read zero", 32'(d), 0);
        bus_write(AW'(0), 8'h00);
        chk("R3 disable ch0", 32'(ch_enable), 0);

        // Sweep every channel in both modes
        for (int c = 0; c < NCH; c++) begin
            for (int m = 0; m < 2; m++) begin
                logic [AW-1:0] a;
                logic [7:0]    mb;
                logic [31:0]   oh;
                a  = AW'(2*c);
                mb = (m != 0) ? 8'h08 : 8'h00;
                oh = 32'(1) << c;

                bus_write(a, mb | 8'h01);
                chk("R3 enable", 32'(ch_enable), oh);
                bus_write(a, mb | 8'h03);
                chk("R4 sw start strobe", 32'(ch_start), oh);
                chk("R4 enable held", 32'(ch_enable), oh);
                tick();
                chk("R4 strobe one cycle", 32'(ch_start), 0);
                hw_req[c] = 1'b1; tick(); hw_req[c] = 1'b0;
                chk("R5 trigger ignored while busy", 32'(ch_start), 0);

                // flag set and read in the same cycle
                tc_evt[c] = 1'b1; bus_addr = a; bus_rd = 1'b1;
                #1 d = bus_rdata;
                chk("R7 read returns prior flag", 32'(d), 32'(mb | 8'h01));
                tick();
                tc_evt[c] = 1'b0; bus_rd = 1'b0;
                chk("R6 enable after finish", 32'(ch_enable), (m != 0) ? oh : 0);

                if (m != 0) begin
                    bus_write(a, mb | 8'h03);
                    chk("R4 sw start refused while flag set", 32'(ch_start), 0);
                end
                hw_req[c] = 1'b1; tick(); hw_req[c] = 1'b0;
                chk("R5 hw start with flag set", 32'(ch_start), (m != 0) ? oh : 0);
                if (m != 0) begin
                    tc_evt[c] = 1'b1; tick(); tc_evt[c] = 1'b0;
                    chk("R6 multi keeps enable", 32'(ch_enable), oh);
                end

                bus_read(a, d);
                chk("R7 set wins over read", 32'(d), 32'(8'h80 | mb | 8'(m)));
                bus_read(a, d);
                chk("R7 read cleared flag", 32'(d), 32'(mb | 8'(m)));

                if (m == 0) begin
                    bus_write(a, 8'h01);
                    hw_req[c] = 1'b1; tick(); hw_req[c] = 1'b0;
                    chk("R5 hw start flag clear", 32'(ch_start), oh);
                    bus_write(a, 8'h05);
                    chk("R8 abort strobe", 32'(ch_abort), oh);
                    chk("R8 enable cleared", 32'(ch_enable), 0);
                end else begin
                    bus_write(a, mb | 8'h03);
                    chk("R4 sw start after clear", 32'(ch_start), oh);
                    nmi = 1'b1; tick(); nmi = 1'b0;
                    chk("R9 nmi disables", 32'(ch_enable), 0);
                    bus_read(a, d);
                    chk("R9 suspended reads disabled", 32'(d), 32'(mb));
                    bus_write(a, mb | 8'h01);
                    chk("R9 resume no strobe", 32'(ch_start), 0);
                    chk("R9 resume enable", 32'(ch_enable), oh);
                    bus_write(a, mb | 8'h04);
                    chk("R8 abort from busy", 32'(ch_abort), oh);
                    chk("R8 enable cleared", 32'(ch_enable), 0);
                end
                bus_write(a, 8'h00);
            end
        end

        // R8 kill while only armed: no strobe
        bus_write(AW'(0), 8'h01);
        bus_write(AW'(0), 8'h05);
        chk("R8 armed kill no strobe", 32'(ch_abort), 0);
        chk("R8 armed kill disables", 32'(ch_enable), 0);

        // R9 nmi clears every channel
        for (int c = 0; c < NCH; c++) bus_write(AW'(2*c), 8'h01);
        chk("R3 all enabled", 32'(ch_enable), (32'(1) << NCH) - 1);
        nmi = 1'b1; tick(); nmi = 1'b0;
        chk("R9 nmi all channels", 32'(ch_enable), 0);

        // R10 kill beats finish
        bus_write(AW'(0), 8'h01);
        bus_write(AW'(0), 8'h03);
        tc_evt[0] = 1'b1;
        bus_write(AW'(0), 8'h05);
        tc_evt[0] = 1'b0;
        chk("R10 kill over finish abort", 32'(ch_abort), 1);
        chk("R10 kill over finish enable", 32'(ch_enable), 0);
        bus_read(AW'(0), d);
        chk("R10 flag still recorded", 32'(d), 32'h80);

        // R10 nmi beats multi-transfer hold
        bus_write(AW'(2), 8'h09);
        bus_write(AW'(2), 8'h0B);
        tc_evt[1] = 1'b1; nmi = 1'b1; tick(); tc_evt[1] = 1'b0; nmi = 1'b0;
        chk("R10 nmi over multi hold", 32'(ch_enable), 0);
        bus_read(AW'(2), d);
        chk("R10 flag and mode", 32'(d), 32'h88);

        summary();
    end
endmodule